// File: doc/BRIEF.md
# SIMD Fixed-Point Precision Converter

This block converts one packed 32-bit operand pair between lane formats: four unsigned bytes, two 16-bit lanes (Q15 fractions or integers), and one Q31 word. One operation code selects the conversion. Conversions that widen a lane place a byte into a 16-bit lane, either as a fraction or as an integer, or place a 16-bit lane into a word. Conversions that narrow a lane keep the upper part of each lane; they either truncate or round and saturate. The block also provides a pack that swaps halves, and replication of an immediate or register value into every lane.

Operands enter through a valid/ready stream port and the result leaves through a second valid/ready port after one register stage. A transfer happens on any clock edge where valid and ready are both high. The input is ready when the output register is empty or is being drained in the same cycle, so a full pipeline still moves one result per cycle. When the output is stalled, the held result and its valid stay unchanged, and no new operand is taken. A sticky flag records that any accepted operation clamped a lane. Only reset clears it.

Top module: `simd_prec_conv`

## Requirements
- R1: Op 0 puts the upper 16 bits of `src_a` into result bits 31:16; op 1 does the same with the lower 16 bits. The other result bits are zero in both cases.
- R2: Ops 2–5 read two bytes of `src_a` as unsigned fractions and turn each into a 16-bit lane `{0, byte, 7'b0}`. The first byte goes to bits 31:16 and the second byte to bits 15:0. The byte pairs are: op 2 = bytes [31:24],[23:16]; op 3 = [15:8],[7:0]; op 4 = [31:24],[15:8]; op 5 = [23:16],[7:0].
- R3: Ops 6–9 select the same byte pairs as ops 2–5, in the same order. Each byte is zero-extended into the low 8 bits of its 16-bit lane.
- R4: Op 10 outputs `{src_a[31:16], src_b[31:16]}`, with no rounding.
- R5: Op 11 adds 0x8000 to each source word and keeps the upper 16 bits. `src_a` supplies bits 31:16 and `src_b` supplies bits 15:0. If a non-negative word would wrap, its lane becomes 0x7FFF and the operation counts as saturating.
- R6: Op 12 keeps bits 15:8 of each 16-bit lane. The result bytes, from high to low, come from the lanes `src_a[31:16]`, `src_a[15:0]`, `src_b[31:16]`, `src_b[15:0]`.
- R7: Op 13 uses the same lane order as op 12 but treats each lane as signed Q15. A negative lane gives 0x00. A lane above 0x7F80 gives 0xFF. Any other lane gives bits 14:7 of (lane + 0x40). Both clamps count as saturating.
- R8: Op 14 outputs `{src_a[15:0], src_b[31:16]}`.
- R9: Op 15 sign-extends the 10-bit `imm` to 16 bits and copies it into both halves. Op 16 copies `src_a[15:0]` into both halves. Op 17 copies `src_a[7:0]` into all four bytes.
- R10: `sat_flag` goes high one cycle after a saturating operation is accepted. It then stays high until reset.
- R11: Whenever `out_valid` is high and `out_ready` is low, `in_ready` is low. On the next cycle `out_valid` and `out_result` are unchanged.
- R12: After reset, `out_valid` and `sat_flag` are low. Op codes 18–31 give a zero result and never saturate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are presented |
| in_ready | output | 1 | Block can take operands |
| op_sel | input | 5 | Conversion select |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| imm | input | 10 | Signed immediate for replication |
| out_valid | output | 1 | Result is held |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Converted result |
| sat_flag | output | 1 | Sticky saturation indicator |

## Verification
Every conversion passes through one register, so a wrong lane select, shift or rounding constant shows as a wrong `out_result` on the very next cycle after acceptance. A clamp that fires when it should not, or misses one it should make, is also visible one cycle later, as a wrong `sat_flag`. Because the flag is sticky, a single false clamp stays visible for the rest of the run. A fault in the handshake shows as a changed or lost held result during a stall, which is checked in the cycle after the stall begins.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;
  localparam int BYTE_W = WORD_W / 4;
  localparam int IMM_W  = 10;
  localparam int OP_W   = 5;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [HALF_W-1:0] half_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [OP_W-1:0] {
    OP_H2W_HI  = 5'd0,
    OP_H2W_LO  = 5'd1,
    OP_FB_HI   = 5'd2,
    OP_FB_LO   = 5'd3,
    OP_FB_AHI  = 5'd4,
    OP_FB_ALO  = 5'd5,
    OP_IB_HI   = 5'd6,
    OP_IB_LO   = 5'd7,
    OP_IB_AHI  = 5'd8,
    OP_IB_ALO  = 5'd9,
    OP_W2H_TR  = 5'd10,
    OP_W2H_RS  = 5'd11,
    OP_H2B_TR  = 5'd12,
    OP_H2B_SAT = 5'd13,
    OP_SWAP    = 5'd14,
    OP_REP_IMM = 5'd15,
    OP_REP_H   = 5'd16,
    OP_REP_B   = 5'd17
  } conv_op_e;
endpackage

// File: rtl/spc_expand.sv
module spc_expand
  import spc_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  word_t           a,
  output word_t           res
);
  byte_t b_first, b_second;
  logic  frac;

  always_comb begin
    case (op)
      OP_FB_HI, OP_IB_HI:   begin b_first = a[31:24]; b_second = a[23:16]; end
      OP_FB_LO, OP_IB_LO:   begin b_first = a[15:8];  b_second = a[7:0];   end
      OP_FB_AHI, OP_IB_AHI: begin b_first = a[31:24]; b_second = a[15:8];  end
      default:              begin b_first = a[23:16]; b_second = a[7:0];   end
    endcase
    frac = (op == OP_FB_HI) || (op == OP_FB_LO) || (op == OP_FB_AHI) || (op == OP_FB_ALO);
  end

  always_comb begin
    if (op == OP_H2W_HI)
      res = {a[WORD_W-1:HALF_W], {HALF_W{1'b0}}};
    else if (op == OP_H2W_LO)
      res = {a[HALF_W-1:0], {HALF_W{1'b0}}};
    else if (frac)
      res = {1'b0, b_first, 7'b0, 1'b0, b_second, 7'b0};
    else
      res = {{BYTE_W{1'b0}}, b_first, {BYTE_W{1'b0}}, b_second};
  end
endmodule

// File: rtl/spc_reduce.sv
module spc_reduce
  import spc_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  word_t           a,
  input  word_t           b,
  output word_t           res,
  output logic            sat
);
  localparam int NW = 2;
  localparam int NH = 4;

  word_t         words [NW];
  half_t         halves[NH];
  half_t         w_rnd [NW];
  logic [NW-1:0] w_sat;
  byte_t         h_tr  [NH];
  byte_t         h_sat [NH];
  logic [NH-1:0] h_clp;

  assign words[0]  = a;
  assign words[1]  = b;
  assign halves[0] = a[31:16];
  assign halves[1] = a[15:0];
  assign halves[2] = b[31:16];
  assign halves[3] = b[15:0];

  for (genvar w = 0; w < NW; w++) begin : g_word
    logic [WORD_W:0] sum;
    always_comb begin
      sum = {words[w][WORD_W-1], words[w]} + (WORD_W+1)'(32'h0000_8000);
      w_sat[w] = !words[w][WORD_W-1] && sum[WORD_W-1];
      w_rnd[w] = w_sat[w] ? 16'h7FFF : sum[WORD_W-1:HALF_W];
    end
  end

  for (genvar h = 0; h < NH; h++) begin : g_half
    half_t bump;
    always_comb begin
      bump = halves[h] + 16'h0040;
      h_tr[h] = halves[h][HALF_W-1:BYTE_W];
      if (halves[h][HALF_W-1]) begin
        h_sat[h] = '0;
        h_clp[h] = 1'b1;
      end else if (halves[h] > 16'h7F80) begin
        h_sat[h] = '1;
        h_clp[h] = 1'b1;
      end else begin
        h_sat[h] = bump[14:7];
        h_clp[h] = 1'b0;
      end
    end
  end

  always_comb begin
    res = '0;
    sat = 1'b0;
    case (op)
      OP_W2H_TR:  res = {a[31:16], b[31:16]};
      OP_W2H_RS:  begin res = {w_rnd[0], w_rnd[1]}; sat = |w_sat; end
      OP_H2B_TR:  res = {h_tr[0], h_tr[1], h_tr[2], h_tr[3]};
      OP_H2B_SAT: begin res = {h_sat[0], h_sat[1], h_sat[2], h_sat[3]}; sat = |h_clp; end
      default:    ;
    endcase
  end
endmodule

// File: rtl/spc_arrange.sv
module spc_arrange
  import spc_pkg::*;
(
  input  logic [OP_W-1:0]  op,
  input  word_t            a,
  input  word_t            b,
  input  logic [IMM_W-1:0] imm,
  output word_t            res
);
  half_t imm_ext;
  assign imm_ext = {{(HALF_W-IMM_W){imm[IMM_W-1]}}, imm};

  always_comb begin
    case (op)
      OP_SWAP:    res = {a[HALF_W-1:0], b[WORD_W-1:HALF_W]};
      OP_REP_IMM: res = {imm_ext, imm_ext};
      OP_REP_H:   res = {2{a[HALF_W-1:0]}};
      OP_REP_B:   res = {4{a[BYTE_W-1:0]}};
      default:    res = '0;
    endcase
  end
endmodule

// File: rtl/simd_prec_conv.sv
module simd_prec_conv
  import spc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  op_sel,
  input  logic [31:0]      src_a,
  input  logic [31:0]      src_b,
  input  logic [IMM_W-1:0] imm,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_result,
  output logic             sat_flag
);
  word_t exp_res, red_res, arr_res, next_res;
  logic  red_sat, next_sat, accept;

  spc_expand  u_exp (.op(op_sel), .a(src_a), .res(exp_res));
  spc_reduce  u_red (.op(op_sel), .a(src_a), .b(src_b), .res(red_res), .sat(red_sat));
  spc_arrange u_arr (.op(op_sel), .a(src_a), .b(src_b), .imm(imm), .res(arr_res));

  always_comb begin
    next_sat = 1'b0;
    if (op_sel <= OP_IB_ALO)
      next_res = exp_res;
    else if (op_sel <= OP_H2B_SAT) begin
      next_res = red_res;
      next_sat = red_sat;
    end else
      next_res = arr_res;
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      sat_flag   <= 1'b0;
    end else begin
      if (accept) begin
        out_valid  <= 1'b1;
        out_result <= next_res;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
      if (accept && next_sat)
        sat_flag <= 1'b1;
    end
  end

  AST_H2W_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (op_sel == OP_H2W_HI || op_sel == OP_H2W_LO) |=> out_result[15:0] == 16'h0); // R1
  AST_FRAC_LANE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_sel >= OP_FB_HI && op_sel <= OP_FB_ALO |=>
      !out_result[31] && !out_result[15] && out_result[6:0] == 7'h0 && out_result[22:16] == 7'h0); // R2
  AST_INT_LANE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_sel >= OP_IB_HI && op_sel <= OP_IB_ALO |=>
      out_result[31:24] == 8'h0 && out_result[15:8] == 8'h0); // R3
  AST_NEG_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_sel == OP_H2B_SAT && src_a[31] |=> out_result[31:24] == 8'h0 && sat_flag); // R7
  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag |=> sat_flag); // R10
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)); // R11
  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_sel > OP_REP_B |=> out_result == 32'h0); // R12
endmodule

// File: tb/simd_prec_conv_tb_top.sv
module simd_prec_conv_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  op_sel = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [9:0]  imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        sat_flag;
  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  simd_prec_conv dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_sel(op_sel), .src_a(src_a), .src_b(src_b), .imm(imm), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .sat_flag(sat_flag));

  // {op, a, b, imm, expected}
  localparam int NV = 24;
  localparam logic [110:0] VEC [NV] = '{
    {5'd0,  32'h81234567, 32'hFEDCBA98, 10'h0,   32'h81230000}, // R1
    {5'd1,  32'h81234567, 32'hFEDCBA98, 10'h0,   32'h45670000}, // R1
    {5'd2,  32'h81234567, 32'hFEDCBA98, 10'h0,   32'h40801180}, // R2
    {5'd3,  32'h81234567, 32'hFEDCBA98, 10'h0,   32'h22803380}, // R2
    {5'd4,  32'h81234567, 32'hFEDCBA98, 10'h0,   32'h40802280}, // R2
    {5'd5,  32'h81234567, 32'hFEDCBA98, 10'h0,   32'h11803380}, // R2
    {5'd6,  32'h81234567, 32'hFEDCBA98, 10'h0,   32'h00810023}, // R3
    {5'd7,  32'h81234567, 32'hFEDCBA98, 10'h0,   32'h00450067}, // R3
    {5'd8,  32'h81234567, 32'hFEDCBA98, 10'h0,   32'h00810045}, // R3
    {5'd9,  32'h81234567, 32'hFEDCBA98, 10'h0,   32'h00230067}, // R3
    {5'd10, 32'h81234567, 32'hFEDCBA98, 10'h0,   32'h8123FEDC}, // R4
    {5'd11, 32'h81234567, 32'hFEDCBA98, 10'h0,   32'h8123FEDD}, // R5
    {5'd11, 32'h7FFF8000, 32'h7FFF7FFF, 10'h0,   32'h7FFF7FFF}, // R5
    {5'd11, 32'h00018000, 32'h00007FFF, 10'h0,   32'h00020000}, // R5
    {5'd12, 32'h81234567, 32'hFEDCBA98, 10'h0,   32'h8145FEBA}, // R6
    {5'd13, 32'h81234567, 32'hFEDCBA98, 10'h0,   32'h008B0000}, // R7
    {5'd13, 32'h7F817F80, 32'h0040003F, 10'h0,   32'hFFFF0100}, // R7
    {5'd14, 32'h81234567, 32'hFEDCBA98, 10'h0,   32'h4567FEDC}, // R8
    {5'd15, 32'h81234567, 32'hFEDCBA98, 10'h200, 32'hFE00FE00}, // R9
    {5'd15, 32'h81234567, 32'hFEDCBA98, 10'h1FF, 32'h01FF01FF}, // R9
    {5'd16, 32'h81234567, 32'hFEDCBA98, 10'h0,   32'h45674567}, // R9
    {5'd17, 32'h81234567, 32'hFEDCBA98, 10'h0,   32'h67676767}, // R9
    {5'd18, 32'h81234567, 32'hFEDCBA98, 10'h3FF, 32'h00000000}, // R12
    {5'd31, 32'hFFFFFFFF, 32'h80000000, 10'h0,   32'h00000000}  // R12
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                      input logic [9:0] im);
    @(negedge clk);
    op_sel = o; src_a = a; src_b = b; imm = im; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    check("R12 reset valid", {31'h0, out_valid}, 32'h0);
    check("R12 reset sat", {31'h0, sat_flag}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][110:106], VEC[i][105:74], VEC[i][73:42], VEC[i][41:32]);
      check($sformatf("vector %0d op %0d", i, VEC[i][110:106]), out_result, VEC[i][31:0]);
      check("R11 valid after accept", {31'h0, out_valid}, 32'h1);
    end

    // R10: sticky flag sequence
    do_reset();
    send(5'd11, 32'h7FFF7FFF, 32'h00000000, 10'h0);
    check("R10 no clamp no flag", {31'h0, sat_flag}, 32'h0);
    send(5'd13, 32'h00100020, 32'h7F800000, 10'h0);
    check("R10 no clamp no flag h2b", {31'h0, sat_flag}, 32'h0);
    send(5'd31, 32'hFFFFFFFF, 32'hFFFFFFFF, 10'h0);
    check("R12 undefined op no flag", {31'h0, sat_flag}, 32'h0);
    send(5'd11, 32'h7FFFFFFF, 32'h00000000, 10'h0);
    check("R5 clamp result", out_result, 32'h7FFF0000);
    check("R10 flag set", {31'h0, sat_flag}, 32'h1);
    send(5'd10, 32'h12345678, 32'h9ABCDEF0, 10'h0);
    check("R10 flag stays", {31'h0, sat_flag}, 32'h1);
    do_reset();
    check("R10 reset clears", {31'h0, sat_flag}, 32'h0);
    send(5'd13, 32'h80000000, 32'h00000000, 10'h0);
    check("R7 negative clamp flags", {31'h0, sat_flag}, 32'h1);

    // R11: back-pressure
    do_reset();
    @(negedge clk);
    out_ready = 1'b0;
    op_sel = 5'd14; src_a = 32'hAAAA1111; src_b = 32'h2222BBBB; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_sel = 5'd17; src_a = 32'h000000C3;
    check("R11 ready low on stall", {31'h0, in_ready}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    check("R11 result held", out_result, 32'h11112222);
    check("R11 valid held", {31'h0, out_valid}, 32'h1);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 next taken after drain", out_result, 32'hC3C3C3C3);
    @(posedge clk);
    @(negedge clk);
    check("R11 drained", {31'h0, out_valid}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule